// File: doc/BRIEF.md
# Serial Register Access Master

This block is a serial-peripheral master that moves single 16-bit register values to and from an external converter. A caller presents a register code, a read/write flag and a write value for one cycle. The block then runs one fixed frame under a single chip-select window and, for a read, returns the 16-bit response together with a one-cycle completion pulse. It has no knowledge of what any register means.

The frame is always 32 bits: a 16-bit command word followed by a 16-bit data word, each sent most significant bit first. For a read, the command word has its top bit forced high and the data slot is filled with all-ones while the response is shifted in. The serial clock idles low. Data is launched on its rising edge and sampled on its falling edge. The serial clock rate comes from a half-period divider value that loads from the caller's side. After reset the block first sends a train of all-ones bytes with the chip select released, so that the clock line settles low before any real frame.

Top module: `spi_reg_master`

## Requirements
- R1: A frame is 32 serial clock periods inside one low period of `spi_cs_n`, in this order: command bits 15..8, command bits 7..0, data bits 15..8, data bits 7..0, each byte sent from its bit 7 down.
- R2: For a write (`req_read`=0) the command word is `req_addr` unchanged and the data word is `req_wdata`.
- R3: For a read (`req_read`=1) the command word is `req_addr` with bit 15 set and the data word is 16'hFFFF. `rdata` takes the 16 bits received in the data slots, the first received bit landing in bit 15. `rdata` changes only in the cycle where `done` is high.
- R4: `spi_sclk` is low whenever the block is not busy. `spi_mosi` changes only as `spi_sclk` rises, and `spi_miso` is sampled as `spi_sclk` falls.
- R5: Between frames `spi_mosi` keeps the level of the last bit sent.
- R6: After reset, `busy` is high while INIT_BYTES bytes of all-ones are clocked with `spi_cs_n` held high. Only then is a request accepted.
- R7: Each serial clock half period lasts a number of system cycles equal to the divider value, which resets to RESET_HALF. A `cfg_wr` pulse loads `cfg_half` only when the block is idle and `cfg_half` is nonzero. Otherwise the pulse is ignored.
- R8: `spi_cs_n` falls at least one half period before the first rising `spi_sclk` edge. It rises exactly one half period after the last falling edge. `spi_sclk` is low at both `spi_cs_n` transitions.
- R9: `busy` rises when a request is accepted and falls in the cycle of the single-cycle `done` pulse. A `req_valid` seen while `busy` is high is dropped and starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Load strobe for the divider value |
| cfg_half | input | DIV_W | New half-period length in system cycles |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_read | input | 1 | 1 selects a read, 0 a write |
| req_addr | input | 16 | Register code |
| req_wdata | input | 16 | Write value |
| busy | output | 1 | Initialisation or frame in progress |
| done | output | 1 | One-cycle pulse at the end of a frame |
| rdata | output | 16 | Read result |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Chip select, active low |

## Verification
The properties assume that the remote device changes `spi_miso` only on rising serial clock edges while selected. They also assume that `cfg_wr` and `req_valid` are one-cycle strobes whose fields hold steady in that cycle. The bench's device model drives `spi_miso` only from rising `spi_sclk` while `spi_cs_n` is low. All caller inputs are driven on the falling system clock edge, as single-cycle pulses. Divider loads are tried both while idle and while a frame runs, so the ignored case is covered without breaking those input assumptions.

// File: rtl/spi_reg_pkg.sv
`timescale 1ns/1ps
package spi_reg_pkg;

    localparam int WORD_W  = 16;
    localparam int FRAME_W = 2 * WORD_W;

    localparam logic [WORD_W-1:0] READ_FLAG = 16'h8000;
    localparam logic [WORD_W-1:0] FILL_WORD = 16'hFFFF;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LEAD,
        PH_SHIFT,
        PH_TRAIL
    } phase_e;

    typedef struct packed {
        logic              rd;
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] wdata;
    } req_t;

    function automatic logic [FRAME_W-1:0] build_frame(req_t r);
        if (r.rd)
            return {r.addr | READ_FLAG, FILL_WORD};
        return {r.addr, r.wdata};
    endfunction

endpackage

// File: rtl/spi_reg_clkdiv.sv
`timescale 1ns/1ps
module spi_reg_clkdiv #(
    parameter int DIV_W      = 16,
    parameter int RESET_HALF = 125
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [DIV_W-1:0] cfg_half,
    input  logic             cfg_allow,
    input  logic             run,
    output logic             tick
);
    logic [DIV_W-1:0] half_q;
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == half_q - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            half_q <= DIV_W'(RESET_HALF);
        end else if (cfg_wr && cfg_allow && (cfg_half != '0)) begin
            half_q <= cfg_half;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/spi_reg_shifter.sv
`timescale 1ns/1ps
module spi_reg_shifter #(
    parameter int FRAME_W = 32,
    parameter int CNT_W   = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [FRAME_W-1:0] load_word,
    input  logic [CNT_W-1:0]   nbits,
    input  logic               step,
    input  logic               miso,
    output logic               sclk,
    output logic               mosi,
    output logic [FRAME_W-1:0] rx_word,
    output logic               last_edge
);
    logic [FRAME_W-1:0] tx_q;
    logic [CNT_W-1:0]   edge_q;
    logic [CNT_W-1:0]   last_idx;

    assign last_idx  = (nbits << 1) - CNT_W'(1);
    assign last_edge = step && sclk && (edge_q == last_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q    <= '1;
            rx_word <= '0;
            sclk    <= 1'b0;
            mosi    <= 1'b0;
            edge_q  <= '0;
        end else if (load) begin
            tx_q   <= load_word;
            edge_q <= '0;
        end else if (step) begin
            edge_q <= edge_q + 1'b1;
            if (!sclk) begin
                sclk <= 1'b1;
                mosi <= tx_q[FRAME_W-1];
                tx_q <= {tx_q[FRAME_W-2:0], 1'b1};
            end else begin
                sclk    <= 1'b0;
                rx_word <= {rx_word[FRAME_W-2:0], miso};
            end
        end
    end
endmodule

// File: rtl/spi_reg_ctrl.sv
`timescale 1ns/1ps
module spi_reg_ctrl
    import spi_reg_pkg::*;
#(
    parameter int INIT_BITS = 80,
    parameter int CNT_W     = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               req_valid,
    input  req_t               req,
    input  logic               last_edge,
    input  logic [WORD_W-1:0]  rx_low,
    output logic               load,
    output logic [FRAME_W-1:0] load_word,
    output logic [CNT_W-1:0]   nbits,
    output logic               step,
    output logic               run,
    output logic               cs_n,
    output logic               busy,
    output logic               done,
    output logic [WORD_W-1:0]  rdata
);
    localparam phase_e RESET_PHASE = (INIT_BITS > 0) ? PH_LEAD : PH_IDLE;

    phase_e phase_q;
    logic   init_q;

    assign load      = (phase_q == PH_IDLE) && req_valid;
    assign load_word = build_frame(req);
    assign nbits     = init_q ? CNT_W'(INIT_BITS) : CNT_W'(FRAME_W);
    assign step      = (phase_q == PH_SHIFT) && tick;
    assign run       = (phase_q != PH_IDLE);
    assign busy      = run;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= RESET_PHASE;
            init_q  <= (INIT_BITS > 0);
            cs_n    <= 1'b1;
            done    <= 1'b0;
            rdata   <= '0;
        end else begin
            done <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (req_valid) begin
                        phase_q <= PH_LEAD;
                        cs_n    <= 1'b0;
                    end
                end
                PH_LEAD: begin
                    if (tick) phase_q <= PH_SHIFT;
                end
                PH_SHIFT: begin
                    if (last_edge) phase_q <= PH_TRAIL;
                end
                PH_TRAIL: begin
                    if (tick) begin
                        phase_q <= PH_IDLE;
                        cs_n    <= 1'b1;
                        init_q  <= 1'b0;
                        if (!init_q) begin
                            done  <= 1'b1;
                            rdata <= rx_low;
                        end
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/spi_reg_master.sv
`timescale 1ns/1ps
module spi_reg_master
    import spi_reg_pkg::*;
#(
    parameter int DIV_W      = 16,
    parameter int RESET_HALF = 125,
    parameter int INIT_BYTES = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [DIV_W-1:0]  cfg_half,
    input  logic              req_valid,
    input  logic              req_read,
    input  logic [15:0]       req_addr,
    input  logic [15:0]       req_wdata,
    output logic              busy,
    output logic              done,
    output logic [15:0]       rdata,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              spi_cs_n
);
    localparam int INIT_BITS = INIT_BYTES * 8;
    localparam int MAX_BITS  = (INIT_BITS > FRAME_W) ? INIT_BITS : FRAME_W;
    localparam int CNT_W     = $clog2(2 * MAX_BITS) + 1;

    req_t               req;
    logic               tick;
    logic               run;
    logic               load;
    logic [FRAME_W-1:0] load_word;
    logic [CNT_W-1:0]   nbits;
    logic               step;
    logic               last_edge;
    logic [FRAME_W-1:0] rx_word;

    assign req = '{rd: req_read, addr: req_addr, wdata: req_wdata};

    spi_reg_clkdiv #(.DIV_W(DIV_W), .RESET_HALF(RESET_HALF)) u_div (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_half  (cfg_half),
        .cfg_allow (!run),
        .run       (run),
        .tick      (tick)
    );

    spi_reg_shifter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_word (load_word),
        .nbits     (nbits),
        .step      (step),
        .miso      (spi_miso),
        .sclk      (spi_sclk),
        .mosi      (spi_mosi),
        .rx_word   (rx_word),
        .last_edge (last_edge)
    );

    spi_reg_ctrl #(.INIT_BITS(INIT_BITS), .CNT_W(CNT_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .req_valid (req_valid),
        .req       (req),
        .last_edge (last_edge),
        .rx_low    (rx_word[WORD_W-1:0]),
        .load      (load),
        .load_word (load_word),
        .nbits     (nbits),
        .step      (step),
        .run       (run),
        .cs_n      (spi_cs_n),
        .busy      (busy),
        .done      (done),
        .rdata     (rdata)
    );
endmodule

// File: rtl/spi_reg_master_chk.sv
`timescale 1ns/1ps
module spi_reg_master_chk (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        done,
    input logic [15:0] rdata,
    input logic        spi_sclk,
    input logic        spi_mosi,
    input logic        spi_cs_n
);
    p_sclk_low_idle_r4: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !spi_sclk);

    p_mosi_on_rise_r4: assert property (@(posedge clk) disable iff (rst)
        !$stable(spi_mosi) |-> $rose(spi_sclk));

    p_mosi_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!busy && $past(!busy)) |-> $stable(spi_mosi));

    p_cs_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !busy |-> spi_cs_n);

    p_cs_edge_clk_low_r8: assert property (@(posedge clk) disable iff (rst)
        ($fell(spi_cs_n) || $rose(spi_cs_n)) |-> !spi_sclk);

    p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_ends_busy_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(busy) && !busy));

    p_rdata_only_on_done_r3: assert property (@(posedge clk) disable iff (rst)
        !$stable(rdata) |-> done);
endmodule

bind spi_reg_master spi_reg_master_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .done     (done),
    .rdata    (rdata),
    .spi_sclk (spi_sclk),
    .spi_mosi (spi_mosi),
    .spi_cs_n (spi_cs_n)
);

// File: tb/spi_reg_master_test.sv
`timescale 1ns/1ps
module spi_reg_master_test;
    localparam int HALF0  = 3;
    localparam int IBYTES = 2;
    localparam int TCLK   = 8;
    localparam int NVEC   = 6;

    // {read, addr, wdata, device response}
    localparam logic [64:0] VEC [NVEC] = '{
        {1'b0, 16'h0800, 16'h2036, 32'h0000_0000},
        {1'b1, 16'h0803, 16'h0000, 32'h1234_A5C3},
        {1'b0, 16'h0040, 16'h0011, 32'hFFFF_FFFF},
        {1'b1, 16'h0000, 16'h5555, 32'h0000_8001},
        {1'b0, 16'h7FFF, 16'hFFFE, 32'h0F0F_0F0F},
        {1'b1, 16'h8004, 16'h1234, 32'h0000_7E01}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [15:0] cfg_half = '0;
    logic        req_valid = 1'b0;
    logic        req_read = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, done, spi_sclk, spi_mosi, spi_cs_n;
    logic        spi_miso = 1'b0;
    logic [15:0] rdata;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // device model state
    logic [31:0] dev_resp = '0;
    logic [31:0] dev_sreg = '0;
    logic [31:0] cap = '0;
    int   cap_n = 0, rise_n = 0, cs_falls = 0, init_falls = 0, init_zero = 0;
    longint t_rise = 0, t_first_rise = 0, t_cs_fall = 0, t_cs_rise = 0, t_last_fall = 0, period = 0;

    always #(TCLK/2) clk = ~clk;

    spi_reg_master #(.DIV_W(16), .RESET_HALF(HALF0), .INIT_BYTES(IBYTES)) uut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_half(cfg_half),
        .req_valid(req_valid), .req_read(req_read), .req_addr(req_addr),
        .req_wdata(req_wdata), .busy(busy), .done(done), .rdata(rdata),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_cs_n(spi_cs_n)
    );

    // device: launches on rising sclk, loads its response at select
    always @(negedge spi_cs_n or posedge spi_sclk) begin
        if (spi_sclk && !spi_cs_n) begin
            spi_miso <= dev_sreg[31];
            dev_sreg <= {dev_sreg[30:0], 1'b0};
        end else if (!spi_sclk) begin
            dev_sreg <= dev_resp;
        end
    end

    always @(negedge spi_sclk) begin
        t_last_fall = $time;
        if (!spi_cs_n) begin
            cap   = {cap[30:0], spi_mosi};
            cap_n = cap_n + 1;
        end else begin
            init_falls = init_falls + 1;
            if (!spi_mosi) init_zero = init_zero + 1;
        end
    end

    always @(posedge spi_sclk) begin
        period = $time - t_rise;
        t_rise = $time;
        if (rise_n == 0) t_first_rise = $time;
        rise_n = rise_n + 1;
    end

    always @(negedge spi_cs_n) begin
        t_cs_fall = $time;
        cs_falls  = cs_falls + 1;
    end
    always @(posedge spi_cs_n) t_cs_rise = $time;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 20000) begin @(negedge clk); n++; end
    endtask

    task automatic run_frame(input bit rd, input logic [15:0] a, input logic [15:0] w,
                             input logic [31:0] resp, output bit got_done);
        int n = 0;
        wait_idle();
        dev_resp = resp; cap_n = 0; rise_n = 0;
        @(negedge clk);
        req_read = rd; req_addr = a; req_wdata = w; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        got_done = 0;
        while (!done && n < 20000) begin @(negedge clk); n++; end
        got_done = done;
    endtask

    task automatic timing_checks(input int half);
        check(period == 2*half*TCLK, "R7 period", period, 2*half*TCLK);
        check((t_first_rise - t_cs_fall) >= half*TCLK, "R8 lead", t_first_rise - t_cs_fall, half*TCLK);
        check((t_cs_rise - t_last_fall) == half*TCLK, "R8 trail", t_cs_rise - t_last_fall, half*TCLK);
    endtask

    initial begin
        #(200000 * TCLK);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        bit gd;
        repeat (3) @(negedge clk);
        // reset state
        check(spi_cs_n === 1'b1, "R6 reset cs_n", spi_cs_n, 1);
        check(spi_sclk === 1'b0, "R4 reset sclk", spi_sclk, 0);
        check(done === 1'b0, "R9 reset done", done, 0);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check(busy === 1'b1, "R6 busy during init", busy, 1);
        wait_idle();
        check(init_falls == IBYTES*8, "R6 init bit count", init_falls, IBYTES*8);
        check(init_zero == 0, "R6 init bytes all ones", init_zero, 0);
        check(cs_falls == 0, "R6 cs_n held high in init", cs_falls, 0);

        // vector table
        for (int i = 0; i < NVEC; i++) begin
            logic [64:0] v;
            logic [31:0] exp_frame;
            v = VEC[i];
            exp_frame = v[64] ? {v[63:48] | 16'h8000, 16'hFFFF} : {v[63:48], v[47:32]};
            run_frame(v[64], v[63:48], v[47:32], v[31:0], gd);
            check(gd, "R9 done seen", gd, 1);
            check(cap == exp_frame, v[64] ? "R3 read frame" : "R2 write frame", cap, exp_frame);
            check(cap_n == 32, "R1 bits per frame", cap_n, 32);
            if (v[64]) check(rdata == v[15:0], "R3 rdata", rdata, v[15:0]);
            timing_checks(HALF0);
            @(negedge clk);
            check(done === 1'b0, "R9 done one cycle", done, 0);
            check(busy === 1'b0, "R9 busy low after done", busy, 0);
        end
        check(cs_falls == NVEC, "R1 one select per frame", cs_falls, NVEC);

        // R5 mosi hold after a frame ending in 0, R4 sclk idle low
        run_frame(1'b0, 16'h1234, 16'h00F0, 32'h0, gd);
        repeat (40) @(negedge clk);
        check(spi_mosi === 1'b0, "R5 mosi holds last bit", spi_mosi, 0);
        check(spi_sclk === 1'b0, "R4 sclk idle low", spi_sclk, 0);

        // R9 request during busy is dropped
        begin
            int falls0;
            falls0 = cs_falls;
            wait_idle();
            dev_resp = 32'h0000_BEEF; cap_n = 0; rise_n = 0;
            @(negedge clk);
            req_read = 1'b1; req_addr = 16'h0011; req_valid = 1'b1;
            @(negedge clk); req_valid = 1'b0;
            repeat (20) @(negedge clk);
            req_read = 1'b0; req_addr = 16'h0022; req_wdata = 16'h0033; req_valid = 1'b1;
            @(negedge clk); req_valid = 1'b0;
            wait_idle();
            repeat (200) @(negedge clk);
            check(cs_falls == falls0 + 1, "R9 busy request dropped", cs_falls, falls0 + 1);
            check(cap == 32'h8011FFFF, "R9 first frame intact", cap, 32'h8011FFFF);
            check(rdata == 16'hBEEF, "R3 rdata after dropped req", rdata, 16'hBEEF);
        end

        // R7 divider load while idle, ignored while busy and when zero
        @(negedge clk); cfg_half = 16'd5; cfg_wr = 1'b1;
        @(negedge clk); cfg_wr = 1'b0;
        run_frame(1'b0, 16'h0101, 16'hA5A5, 32'h0, gd);
        check(cap == 32'h0101A5A5, "R2 frame at new rate", cap, 32'h0101A5A5);
        timing_checks(5);
        begin
            dev_resp = 32'h0; cap_n = 0; rise_n = 0;
            @(negedge clk);
            req_read = 1'b0; req_addr = 16'h0202; req_wdata = 16'h0303; req_valid = 1'b1;
            @(negedge clk); req_valid = 1'b0;
            repeat (10) @(negedge clk);
            cfg_half = 16'd9; cfg_wr = 1'b1;
            @(negedge clk); cfg_wr = 1'b0;
            wait_idle();
        end
        @(negedge clk); cfg_half = 16'd0; cfg_wr = 1'b1;
        @(negedge clk); cfg_wr = 1'b0;
        run_frame(1'b1, 16'h0404, 16'h0, 32'h0000_3C3C, gd);
        check(rdata == 16'h3C3C, "R3 rdata at kept rate", rdata, 16'h3C3C);
        timing_checks(5);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule